// File: doc/BRIEF.md
# Cache Transfer Acknowledge Generator

This block sits beside a secondary-cache tag store and decides, every cycle, whether the processor's current bus transfer is acknowledged from the cache. The acknowledge is active low. It takes the tag comparator's qualified hit, the valid and write-through bits stored for the addressed entry, and the processor's read/write type. From these it builds one acknowledge level.

Several inputs can take priority over the compare result:
- An output-enable input can take the acknowledge off the bus altogether.
- An external acknowledge input is captured on the rising clock and, when sampled low, drives the acknowledge active regardless of the cache state.
- Any tag read or tag/status write in progress holds the acknowledge inactive.
- A force input holds the acknowledge inactive.
- In dedicated mode, an invalid entry holds the acknowledge inactive.
- In dedicated mode, a write to a write-through line holds the acknowledge inactive.

In generic mode the two status bits carry no meaning for this block. A qualifier output says whether the acknowledge pin is being driven. When it is not, the pin is modelled as held inactive (high).

Top module: `ta_gen`

## Requirements
- R1: While `ack_oe_ni` is 1, `ack_valid_o` is 0 and `ack_no` is 1, whatever the other inputs are.
- R2: `ext_ack_ni` is sampled on each rising edge of `clk_i`. While the most recent sample is 0 and `ack_oe_ni` is 0, `ack_no` is 0. This overrides R3 to R7.
- R3: When the last `ext_ack_ni` sample is 1, `ack_no` is 1 if any of `tag_oe_ni`, `tag_we_ni` or `stat_we_ni` is 0.
- R4: When neither R2 nor R3 applies, `force_hi_i` = 1 makes `ack_no` 1.
- R5: In dedicated mode (`generic_mode_i` = 0), when none of R2 to R4 applies, `vld_i` = 0 makes `ack_no` 1.
- R6: In dedicated mode, when none of R2 to R5 applies, a write cycle (`rd_wr_i` = 0) with `wt_i` = 1 makes `ack_no` 1.
- R7: When none of R2 to R6 applies, `ack_no` is the inverse of `match_i`: 0 on a hit, 1 on a miss.
- R8: In generic mode (`generic_mode_i` = 1), `vld_i` and `wt_i` have no effect on `ack_no`.
- R9: While `rst_ni` is 0, `ack_valid_o` is 0 and `ack_no` is 1. The captured external acknowledge returns to inactive (1).
- R10: A change on `ext_ack_ni` between rising edges has no effect on `ack_no` until the next rising edge. The captured value holds for the whole cycle.
- R11: While `rst_ni` is 1 and `ack_oe_ni` is 0, `ack_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; external acknowledge is captured on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | 1 | Qualified tag compare result, 1 = hit |
| vld_i | input | 1 | Stored valid bit of the addressed entry |
| wt_i | input | 1 | Stored write-through bit of the addressed entry |
| rd_wr_i | input | 1 | Processor transfer type, 1 = read, 0 = write |
| force_hi_i | input | 1 | Forces the acknowledge inactive |
| ext_ack_ni | input | 1 | External acknowledge, active low, synchronous |
| tag_oe_ni | input | 1 | Tag read enable, active low |
| tag_we_ni | input | 1 | Tag write enable, active low |
| stat_we_ni | input | 1 | Status write enable, active low |
| generic_mode_i | input | 1 | 0 = dedicated status meaning, 1 = generic status bits |
| ack_oe_ni | input | 1 | Acknowledge output enable, active low |
| ack_no | output | 1 | Transfer acknowledge, active low |
| ack_valid_o | output | 1 | 1 when `ack_no` is driven |

## Verification
The assertions check every rule of the priority chain on every cycle, each rule under the exact conditions that select it. They also check the output disable, the reset state and the qualifier. They relate the outputs to the captured external acknowledge held inside the block. Two things only the bench scenarios can show: that the capture happens on the rising edge alone, and that a pulse on `ext_ack_ni` between edges leaves the output alone. The bench shows both with a reference model of the capture register, driven only from the ports. The bench also checks that generic mode ignores the status bits, by flipping those bits with everything else held fixed.

// File: rtl/ta_pkg.sv
package ta_pkg;
  // Which rule owns the acknowledge this cycle, highest priority first
  typedef enum logic [2:0] {
    SRC_OFF     = 3'd0,
    SRC_EXT     = 3'd1,
    SRC_BUSY    = 3'd2,
    SRC_FORCE   = 3'd3,
    SRC_INVALID = 3'd4,
    SRC_WTHRU   = 3'd5,
    SRC_CMP     = 3'd6
  } ta_src_e;
endpackage

// File: rtl/ta_ext_sampler.sv
module ta_ext_sampler #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_ack_ni,
  output logic ext_q_no
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b1;
          else         chain_q[0] <= ext_ack_ni;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b1;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign ext_q_no = chain_q[LAST];
endmodule

// File: rtl/ta_arbiter.sv
module ta_arbiter
  import ta_pkg::*;
(
  input  logic    ack_oe_ni,
  input  logic    ext_q_no,
  input  logic    tag_oe_ni,
  input  logic    tag_we_ni,
  input  logic    stat_we_ni,
  input  logic    force_hi_i,
  input  logic    generic_mode_i,
  input  logic    vld_i,
  input  logic    wt_i,
  input  logic    rd_wr_i,
  output ta_src_e src_o
);
  logic busy;
  logic dedicated;

  assign busy      = ~(tag_oe_ni & tag_we_ni & stat_we_ni);
  assign dedicated = ~generic_mode_i;

  always_comb begin
    if (ack_oe_ni)                      src_o = SRC_OFF;
    else if (!ext_q_no)                 src_o = SRC_EXT;
    else if (busy)                      src_o = SRC_BUSY;
    else if (force_hi_i)                src_o = SRC_FORCE;
    else if (dedicated && !vld_i)       src_o = SRC_INVALID;
    else if (dedicated && !rd_wr_i && wt_i) src_o = SRC_WTHRU;
    else                                src_o = SRC_CMP;
  end
endmodule

// File: rtl/ta_drive.sv
module ta_drive
  import ta_pkg::*;
(
  input  logic    rst_ni,
  input  ta_src_e src_i,
  input  logic    match_i,
  output logic    ack_no,
  output logic    ack_valid_o
);
  always_comb begin
    ack_valid_o = rst_ni;
    ack_no      = 1'b1;
    if (!rst_ni) begin
      ack_no = 1'b1;
    end else begin
      unique case (src_i)
        SRC_OFF: begin
          ack_valid_o = 1'b0;
          ack_no      = 1'b1;
        end
        SRC_EXT: ack_no = 1'b0;
        SRC_CMP: ack_no = ~match_i;
        default: ack_no = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ta_gen.sv
module ta_gen
  import ta_pkg::*;
#(
  parameter int unsigned EXT_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic vld_i,
  input  logic wt_i,
  input  logic rd_wr_i,
  input  logic force_hi_i,
  input  logic ext_ack_ni,
  input  logic tag_oe_ni,
  input  logic tag_we_ni,
  input  logic stat_we_ni,
  input  logic generic_mode_i,
  input  logic ack_oe_ni,
  output logic ack_no,
  output logic ack_valid_o
);
  logic    ext_q_n;
  ta_src_e src;

  ta_ext_sampler #(.STAGES(EXT_STAGES)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_ack_ni (ext_ack_ni),
    .ext_q_no   (ext_q_n)
  );

  ta_arbiter u_arb (
    .ack_oe_ni      (ack_oe_ni),
    .ext_q_no       (ext_q_n),
    .tag_oe_ni      (tag_oe_ni),
    .tag_we_ni      (tag_we_ni),
    .stat_we_ni     (stat_we_ni),
    .force_hi_i     (force_hi_i),
    .generic_mode_i (generic_mode_i),
    .vld_i          (vld_i),
    .wt_i           (wt_i),
    .rd_wr_i        (rd_wr_i),
    .src_o          (src)
  );

  ta_drive u_drive (
    .rst_ni      (rst_ni),
    .src_i       (src),
    .match_i     (match_i),
    .ack_no      (ack_no),
    .ack_valid_o (ack_valid_o)
  );
endmodule

// File: rtl/ta_gen_chk.sv
module ta_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic match_i,
  input logic vld_i,
  input logic wt_i,
  input logic rd_wr_i,
  input logic force_hi_i,
  input logic tag_oe_ni,
  input logic tag_we_ni,
  input logic stat_we_ni,
  input logic generic_mode_i,
  input logic ack_oe_ni,
  input logic ext_q_n,
  input logic ack_no,
  input logic ack_valid_o
);
  logic busy, ded, on;
  assign busy = !tag_oe_ni || !tag_we_ni || !stat_we_ni;
  assign ded  = !generic_mode_i;
  assign on   = !ack_oe_ni && ext_q_n;

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_oe_ni |-> (!ack_valid_o && ack_no)); // R1
  AST_EXT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_oe_ni && !ext_q_n) |-> !ack_no); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && busy) |-> ack_no); // R3
  AST_FORCE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && !busy && force_hi_i) |-> ack_no); // R4
  AST_INVALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && !busy && !force_hi_i && ded && !vld_i) |-> ack_no); // R5
  AST_WTHRU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && !busy && !force_hi_i && ded && vld_i && !rd_wr_i && wt_i) |-> ack_no); // R6
  AST_CMP_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && !busy && !force_hi_i && (!ded || (vld_i && (rd_wr_i || !wt_i))))
      |-> (ack_no == !match_i)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!ack_valid_o && ack_no)); // R9
  AST_VALID_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_oe_ni |-> ack_valid_o); // R11
endmodule

bind ta_gen ta_gen_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .match_i        (match_i),
  .vld_i          (vld_i),
  .wt_i           (wt_i),
  .rd_wr_i        (rd_wr_i),
  .force_hi_i     (force_hi_i),
  .tag_oe_ni      (tag_oe_ni),
  .tag_we_ni      (tag_we_ni),
  .stat_we_ni     (stat_we_ni),
  .generic_mode_i (generic_mode_i),
  .ack_oe_ni      (ack_oe_ni),
  .ext_q_n        (ext_q_n),
  .ack_no         (ack_no),
  .ack_valid_o    (ack_valid_o)
);

// File: tb/tb_ta_gen.sv
module tb_ta_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic match, vld, wt, rd_wr, force_hi, ext_n, tag_oe_n, tag_we_n, stat_we_n, gen_mode, oe_n;
  logic ack_n, ack_valid;
  logic model_q;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ta_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .match_i(match), .vld_i(vld), .wt_i(wt),
    .rd_wr_i(rd_wr), .force_hi_i(force_hi), .ext_ack_ni(ext_n),
    .tag_oe_ni(tag_oe_n), .tag_we_ni(tag_we_n), .stat_we_ni(stat_we_n),
    .generic_mode_i(gen_mode), .ack_oe_ni(oe_n), .ack_no(ack_n), .ack_valid_o(ack_valid)
  );

  // reference of the captured external acknowledge, built from the ports
  always @(posedge clk or negedge rst_n)
    if (!rst_n) model_q <= 1'b1;
    else        model_q <= ext_n;

  function automatic logic exp_ack();
    if (!rst_n || oe_n)                        return 1'b1;
    if (!model_q)                              return 1'b0;
    if (!tag_oe_n || !tag_we_n || !stat_we_n)  return 1'b1;
    if (force_hi)                              return 1'b1;
    if (!gen_mode && !vld)                     return 1'b1;
    if (!gen_mode && !rd_wr && wt)             return 1'b1;
    return !match;
  endfunction

  function automatic logic exp_valid();
    return rst_n && !oe_n;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check(req, ack_n, exp_ack());
    check(req, ack_valid, exp_valid());
  endtask

  task automatic idle();
    match = 1; vld = 1; wt = 0; rd_wr = 1; force_hi = 0; ext_n = 1;
    tag_oe_n = 1; tag_we_n = 1; stat_we_n = 1; gen_mode = 0; oe_n = 0;
  endtask

  task automatic randomize_in();
    match     = 1'($urandom_range(0, 1));
    vld       = ($urandom_range(0, 9) < 8);
    wt        = 1'($urandom_range(0, 1));
    rd_wr     = 1'($urandom_range(0, 1));
    force_hi  = ($urandom_range(0, 9) < 2);
    ext_n     = ($urandom_range(0, 9) < 8);
    tag_oe_n  = ($urandom_range(0, 19) < 18);
    tag_we_n  = ($urandom_range(0, 19) < 18);
    stat_we_n = ($urandom_range(0, 19) < 18);
    gen_mode  = 1'($urandom_range(0, 1));
    oe_n      = ($urandom_range(0, 9) < 1);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_7a11));
    idle();
    ext_n = 0;
    repeat (3) @(posedge clk);
    #5;
    check("R9 reset ack", ack_n, 1'b1);
    check("R9 reset valid", ack_valid, 1'b0);
    @(negedge clk); rst_n = 1; ext_n = 1;
    #2;
    check("R9 capture cleared", ack_n, 1'b0 == 1'b1 ? 1'b0 : !match);
    check("R11 valid after reset", ack_valid, 1'b1);

    // R1 output disable
    @(negedge clk); oe_n = 1; #2;
    check("R1 disabled ack", ack_n, 1'b1);
    check("R1 disabled valid", ack_valid, 1'b0);
    oe_n = 0;

    // R2 external ack overrides everything below it
    @(negedge clk); ext_n = 0; tag_we_n = 0; force_hi = 1; match = 0;
    #2; check("R2 before edge", ack_n, 1'b1);
    @(posedge clk); #2;
    check("R2 ext ack low", ack_n, 1'b0);
    @(negedge clk); ext_n = 1; #2;
    check("R10 ext held until edge", ack_n, 1'b0);
    @(posedge clk); #2;
    check("R3 busy after ext release", ack_n, 1'b1);

    // R10 pulse between edges is ignored
    idle();
    @(posedge clk); #3; ext_n = 0; #4; ext_n = 1;
    @(posedge clk); #2;
    check("R10 pulse ignored", ack_n, 1'b0 ^ !match);
    check_all("R10 pulse ignored model");

    // R3 each busy source
    idle(); tag_oe_n = 0;  @(negedge clk); #2; check("R3 tag read", ack_n, 1'b1);
    idle(); stat_we_n = 0; @(negedge clk); #2; check("R3 status write", ack_n, 1'b1);
    // R4
    idle(); force_hi = 1; @(negedge clk); #2; check("R4 force", ack_n, 1'b1);
    // R5
    idle(); vld = 0; @(negedge clk); #2; check("R5 invalid entry", ack_n, 1'b1);
    // R6
    idle(); rd_wr = 0; wt = 1; @(negedge clk); #2; check("R6 write-through write", ack_n, 1'b1);
    idle(); rd_wr = 1; wt = 1; @(negedge clk); #2; check("R6 write-through read hits", ack_n, 1'b0);
    // R7
    idle(); match = 0; @(negedge clk); #2; check("R7 miss", ack_n, 1'b1);
    idle(); match = 1; @(negedge clk); #2; check("R7 hit", ack_n, 1'b0);

    // R8 generic mode ignores status bits
    idle(); gen_mode = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); vld = i[0]; wt = i[1]; rd_wr = 0; #2;
      check("R8 generic ignores status", ack_n, 1'b0);
    end

    // random mix
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      randomize_in();
      #3;
      check_all("R2-R8 random priority");
      if (n % 500 == 250) begin
        rst_n = 0; #1;
        check("R9 async reset", ack_n, 1'b1);
        check("R9 async reset valid", ack_valid, 1'b0);
        @(negedge clk); rst_n = 1;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule